// File: doc/BRIEF.md
# Interval timer with interrupt modes

This block is a presettable down-counter that divides one of four externally supplied tick enables into a repeating interval. When the counter expires it raises an interval event, reloads itself from the stored preset and keeps counting. The event sets a sticky flag that only software can clear.

The event also asserts a pull-down request for an active-low, open-drain interrupt pin. The pin driver sits outside this block: when `irq_pull_o` is high the pin is driven low, and when it is low the pin floats. The request has two styles. In level style it holds until software clears the flag. In pulse style it releases by itself after a return window. The window is counted on a separate reference tick, and its length depends on which tick source is selected.

The tick enables and the reference tick are single-cycle strobes in the `clk_i` domain. They come from a divider that is not part of this block.

Top module: `ivl_timer`

## Requirements
- R1: `src_sel_i` picks the tick that advances the counter. Value 0 selects `tick_src_i[0]` (4096 Hz), 1 selects `tick_src_i[1]` (64 Hz), 2 selects `tick_src_i[2]` (1 Hz) and 3 selects `tick_src_i[3]` (1/60 Hz). Strobes on the three unselected inputs have no effect on `count_o` or on events.
- R2: While `run_i` is high, each selected tick lowers `count_o` by one. A tick that finds the count at 1 or 0 instead fires an event and reloads the preset. A preset P of 1 or more therefore gives one event every P ticks, and a preset of 0 gives an event on every tick.
- R3: A cycle with `preset_wr_i` high stores `preset_i` and shows it on `count_o` in the next cycle, whether the timer is running or not. If a selected tick arrives in the same cycle, the write wins and no event fires.
- R4: While `run_i` is low, `count_o` equals the stored preset and ticks cause no events. Counting starts from the preset once `run_i` goes high.
- R5: `flag_o` goes high in the cycle after an event and stays high until a `flag_clr_i` strobe. If an event and a clear fall in the same cycle, the flag stays high. No input sets the flag except an event.
- R6: Level style (`pulse_mode_i` = 0), with `irq_en_i` high: `irq_pull_o` rises in the cycle after an event and holds until a `flag_clr_i` strobe, with no limit on how long that takes.
- R7: Pulse style (`pulse_mode_i` = 1), with `irq_en_i` high: `irq_pull_o` rises after an event and falls at the N-th `ref_tick_i` strobe after the event. N is `RTN_FAST` for sources 0 and 3, `RTN_MID` for source 1 and `RTN_SLOW` for source 2. A flag clear does not cut the pulse short, and the flag stays set after the pulse ends.
- R8: While `irq_en_i` is low, `irq_pull_o` stays low and any pending request is dropped. After re-enabling, events that happened while disabled do not show on `irq_pull_o`, although they still set `flag_o`.
- R9: During reset, `count_o`, the stored preset, `flag_o` and `irq_pull_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_src_i | input | 4 | Tick strobes: [0] 4096 Hz, [1] 64 Hz, [2] 1 Hz, [3] 1/60 Hz |
| ref_tick_i | input | 1 | Reference strobe used to time the pulse-style return window |
| src_sel_i | input | 2 | Selects which tick strobe drives the counter |
| preset_i | input | CNT_W | Preset value to store |
| preset_wr_i | input | 1 | Write strobe: stores the preset and loads the counter |
| run_i | input | 1 | Timer enable; while low the counter holds the preset |
| irq_en_i | input | 1 | Interrupt request enable |
| pulse_mode_i | input | 1 | 0 selects level style, 1 selects pulse style |
| flag_clr_i | input | 1 | Clears the sticky event flag |
| flag_o | output | 1 | Sticky event flag |
| irq_pull_o | output | 1 | Request to drive the active-low interrupt pin low |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench keeps `CNT_W` at 8 and shortens the return windows to `RTN_FAST`=1, `RTN_MID`=3 and `RTN_SLOW`=5. Because the three windows differ, a wrong source-to-window mapping shows up as a wrong release strobe. Because they are short, every source's window, including the longest, is exercised strobe by strobe in a few dozen cycles instead of thousands of reference ticks. The 8-bit counter lets the vector table reach the full-scale preset of 255 alongside the 0 and 1 reload corner cases.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned SEL_W   = 2;

   typedef enum logic [SEL_W-1:0] {
      SRC_FAST = 2'd0,
      SRC_MID  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_MIN  = 2'd3
   } src_sel_e;

   typedef enum logic {
      IRQ_LEVEL = 1'b0,
      IRQ_PULSE = 1'b1
   } irq_style_e;
endpackage

// File: rtl/ivl_tick_sel.sv
module ivl_tick_sel #(
   parameter int unsigned NSRC  = 4,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned RTN_W = 13,
   parameter logic [NSRC*RTN_W-1:0] RTN_TBL = '0
) (
   input  logic [NSRC-1:0]  tick_src_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o,
   output logic [RTN_W-1:0] rtn_len_o
);
   if (NSRC > (1 << SEL_W)) begin : g_bad_sel
      $error("ivl_tick_sel: select too narrow for source count");
   end

   logic [NSRC-1:0]  hit;
   logic [RTN_W-1:0] len_pick [NSRC];

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam logic [RTN_W-1:0] LEN = RTN_TBL[g*RTN_W +: RTN_W];
      if (LEN == '0) begin : g_bad_len
         $error("ivl_tick_sel: return window must be at least one tick");
      end
      assign hit[g]      = tick_src_i[g] && (sel_i == SEL_W'(g));
      assign len_pick[g] = (sel_i == SEL_W'(g)) ? LEN : '0;
   end

   assign tick_o = |hit;

   always_comb begin
      rtn_len_o = '0;
      for (int i = 0; i < NSRC; i++) begin
         rtn_len_o = rtn_len_o | len_pick[i];
      end
   end
endmodule

// File: rtl/ivl_down_cnt.sv
module ivl_down_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic             preset_wr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             evt_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("ivl_down_cnt: counter must be at least 2 bits");
   end

   logic [CNT_W-1:0] preset_q;
   logic [CNT_W-1:0] count_q;
   logic             expire;

   // The tick that would take the count to zero reloads instead.
   assign expire = (count_q <= CNT_W'(1));
   assign evt_o  = run_i && tick_i && !preset_wr_i && expire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         preset_q <= '0;
         count_q  <= '0;
      end else if (preset_wr_i) begin
         preset_q <= preset_i;
         count_q  <= preset_i;
      end else if (!run_i) begin
         count_q  <= preset_q;
      end else if (tick_i) begin
         count_q  <= expire ? preset_q : count_q - 1'b1;
      end
   end

   assign count_o = count_q;

   assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= preset_q)
      else $error("count above preset");

   assert_wr_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      preset_wr_i |=> (count_q == $past(preset_i)))
      else $error("preset write did not load counter");

   assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !preset_wr_i) |=> (count_q == preset_q))
      else $error("stopped counter left preset");
endmodule

// File: rtl/ivl_irq_out.sv
module ivl_irq_out #(
   parameter int unsigned RTN_W         = 13,
   parameter bit          FLAG_SET_WINS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             evt_i,
   input  logic             ref_tick_i,
   input  logic [RTN_W-1:0] rtn_len_i,
   input  logic             irq_en_i,
   input  logic             pulse_mode_i,
   input  logic             flag_clr_i,
   output logic             flag_o,
   output logic             irq_pull_o
);
   logic             flag_q;
   logic             flag_d;
   logic             active_q;
   logic [RTN_W-1:0] rtn_q;

   if (FLAG_SET_WINS) begin : g_set_wins
      assign flag_d = evt_i | (flag_q & ~flag_clr_i);
   end else begin : g_clr_wins
      assign flag_d = (evt_i | flag_q) & ~flag_clr_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         rtn_q    <= '0;
      end else if (!irq_en_i) begin
         active_q <= 1'b0;
         rtn_q    <= '0;
      end else if (evt_i) begin
         active_q <= 1'b1;
         rtn_q    <= pulse_mode_i ? rtn_len_i : '0;
      end else if (!pulse_mode_i) begin
         rtn_q <= '0;
         if (flag_clr_i) active_q <= 1'b0;
      end else if (active_q && ref_tick_i) begin
         if (rtn_q <= RTN_W'(1)) begin
            active_q <= 1'b0;
            rtn_q    <= '0;
         end else begin
            rtn_q <= rtn_q - 1'b1;
         end
      end
   end

   assign flag_o     = flag_q;
   assign irq_pull_o = active_q & irq_en_i;

   assert_flag_from_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q) |-> $past(evt_i))
      else $error("flag set without event");

   if (FLAG_SET_WINS) begin : g_chk_flag
      assert_req_has_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(active_q) |-> flag_q)
         else $error("request raised with flag clear");
   end

   assert_pulse_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(active_q) && pulse_mode_i) |-> (rtn_q != '0))
      else $error("pulse started with empty window");

   assert_req_from_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_pull_o) |-> $past(evt_i))
      else $error("request rose without event");
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int unsigned CNT_W         = 8,
   parameter int unsigned RTN_FAST      = 1,
   parameter int unsigned RTN_MID       = 64,
   parameter int unsigned RTN_SLOW      = 4096,
   parameter bit          FLAG_SET_WINS = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] tick_src_i,
   input  logic               ref_tick_i,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  logic [CNT_W-1:0]   preset_i,
   input  logic               preset_wr_i,
   input  logic               run_i,
   input  logic               irq_en_i,
   input  logic               pulse_mode_i,
   input  logic               flag_clr_i,
   output logic               flag_o,
   output logic               irq_pull_o,
   output logic [CNT_W-1:0]   count_o
);
   localparam int unsigned RTN_MAX_A = (RTN_FAST > RTN_MID) ? RTN_FAST : RTN_MID;
   localparam int unsigned RTN_MAX   = (RTN_MAX_A > RTN_SLOW) ? RTN_MAX_A : RTN_SLOW;
   localparam int unsigned RTN_W     = $clog2(RTN_MAX + 1);
   // Window per source index, highest index first.
   localparam logic [NUM_SRC*RTN_W-1:0] RTN_TBL = {
      RTN_W'(RTN_FAST), RTN_W'(RTN_SLOW), RTN_W'(RTN_MID), RTN_W'(RTN_FAST)};

   if (RTN_FAST == 0 || RTN_MID == 0 || RTN_SLOW == 0) begin : g_bad_rtn
      $error("ivl_timer: return windows must be nonzero");
   end

   logic             tick;
   logic             evt;
   logic [RTN_W-1:0] rtn_len;

   ivl_tick_sel #(
      .NSRC    (NUM_SRC),
      .SEL_W   (SEL_W),
      .RTN_W   (RTN_W),
      .RTN_TBL (RTN_TBL)
   ) u_tick_sel (
      .tick_src_i (tick_src_i),
      .sel_i      (src_sel_i),
      .tick_o     (tick),
      .rtn_len_o  (rtn_len)
   );

   ivl_down_cnt #(
      .CNT_W (CNT_W)
   ) u_down_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .run_i       (run_i),
      .preset_i    (preset_i),
      .preset_wr_i (preset_wr_i),
      .count_o     (count_o),
      .evt_o       (evt)
   );

   ivl_irq_out #(
      .RTN_W         (RTN_W),
      .FLAG_SET_WINS (FLAG_SET_WINS)
   ) u_irq_out (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt),
      .ref_tick_i   (ref_tick_i),
      .rtn_len_i    (rtn_len),
      .irq_en_i     (irq_en_i),
      .pulse_mode_i (pulse_mode_i),
      .flag_clr_i   (flag_clr_i),
      .flag_o       (flag_o),
      .irq_pull_o   (irq_pull_o)
   );

   assert_evt_needs_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt |-> tick_src_i[src_sel_i])
      else $error("event without selected tick");

   assert_reset_idle_R9: assert property (@(posedge clk_i)
      !rst_ni |-> (!flag_o && !irq_pull_o && count_o == '0))
      else $error("outputs not idle in reset");
endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] tick_src;
   logic       ref_tick;
   logic [1:0] src_sel;
   logic [7:0] preset;
   logic       preset_wr;
   logic       run;
   logic       irq_en;
   logic       pulse_mode;
   logic       flag_clr;
   logic       flag;
   logic       irq_pull;
   logic [7:0] count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ivl_timer #(
      .CNT_W    (8),
      .RTN_FAST (1),
      .RTN_MID  (3),
      .RTN_SLOW (5)
   ) u_ivl_timer (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tick_src_i   (tick_src),
      .ref_tick_i   (ref_tick),
      .src_sel_i    (src_sel),
      .preset_i     (preset),
      .preset_wr_i  (preset_wr),
      .run_i        (run),
      .irq_en_i     (irq_en),
      .pulse_mode_i (pulse_mode),
      .flag_clr_i   (flag_clr),
      .flag_o       (flag),
      .irq_pull_o   (irq_pull),
      .count_o      (count)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic [7:0] pre;
      logic [7:0] n;
      logic [7:0] ev;
      logic [7:0] cnt;
   } vec_t;

   // events = n/P and count = P - n%P for P >= 1; P = 0 fires every tick
   localparam vec_t VECS [6] = '{
      '{sel: 2'd0, pre: 8'd3,   n: 8'd7, ev: 8'd2, cnt: 8'd2},
      '{sel: 2'd1, pre: 8'd1,   n: 8'd4, ev: 8'd4, cnt: 8'd1},
      '{sel: 2'd2, pre: 8'd0,   n: 8'd3, ev: 8'd3, cnt: 8'd0},
      '{sel: 2'd3, pre: 8'd5,   n: 8'd4, ev: 8'd0, cnt: 8'd1},
      '{sel: 2'd0, pre: 8'd255, n: 8'd2, ev: 8'd0, cnt: 8'd253},
      '{sel: 2'd2, pre: 8'd2,   n: 8'd6, ev: 8'd3, cnt: 8'd2}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tick(input int s);
      tick_src[s] = 1'b1;
      step();
      tick_src = '0;
   endtask

   task automatic others(input int s);
      tick_src = ~(4'b0001 << s);
      step();
      tick_src = '0;
   endtask

   task automatic write_preset(input logic [7:0] v);
      preset    = v;
      preset_wr = 1'b1;
      step();
      preset_wr = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
   endtask

   task automatic ref_pulse();
      ref_tick = 1'b1;
      step();
      ref_tick = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int evn;
      rst_n = 1'b0; tick_src = '0; ref_tick = 1'b0; src_sel = '0;
      preset = '0; preset_wr = 1'b0; run = 1'b0; irq_en = 1'b0;
      pulse_mode = 1'b0; flag_clr = 1'b0;
      repeat (3) step();
      check("R9 count in reset", count, 0);
      check("R9 flag in reset", flag, 0);
      check("R9 request in reset", irq_pull, 0);
      rst_n = 1'b1;
      step();
      check("R9 count after reset", count, 0);

      // Table walk: R1 source routing, R2 counting and reload
      for (int v = 0; v < 6; v++) begin
         run     = 1'b0;
         src_sel = VECS[v].sel;
         write_preset(VECS[v].pre);
         run = 1'b1;
         evn = 0;
         for (int k = 0; k < int'(VECS[v].n); k++) begin
            others(int'(VECS[v].sel));
            tick(int'(VECS[v].sel));
            if (flag) begin
               evn++;
               clear_flag();
            end
         end
         check($sformatf("R1 R2 events vec%0d", v), evn, VECS[v].ev);
         check($sformatf("R1 R2 count vec%0d", v), count, VECS[v].cnt);
      end

      // R3: write while running, and write beating a tick
      src_sel = 2'd0;
      write_preset(8'd9);
      check("R3 write while running", count, 9);
      tick(0);
      check("R2 decrement after write", count, 8);
      write_preset(8'd1);
      preset = 8'd4; preset_wr = 1'b1; tick_src[0] = 1'b1;
      step();
      preset_wr = 1'b0; tick_src = '0;
      check("R3 write beats tick count", count, 4);
      check("R3 write beats tick no event", flag, 0);

      // R4: stopped timer holds the preset
      run = 1'b0;
      write_preset(8'd6);
      tick(0); tick(0); tick(0);
      check("R4 stopped count", count, 6);
      check("R4 stopped no event", flag, 0);
      run = 1'b1;
      tick(0);
      check("R4 count starts from preset", count, 5);

      // R5: sticky flag, set wins over a same-cycle clear
      write_preset(8'd1);
      tick(0);
      check("R5 flag after event", flag, 1);
      repeat (5) step();
      check("R5 flag sticky", flag, 1);
      flag_clr = 1'b1; tick_src[0] = 1'b1;
      step();
      flag_clr = 1'b0; tick_src = '0;
      check("R5 event beats clear", flag, 1);
      clear_flag();
      check("R5 flag cleared", flag, 0);

      // R6: level style
      irq_en = 1'b1; pulse_mode = 1'b0;
      tick(0);
      check("R6 level request raised", irq_pull, 1);
      repeat (4) ref_pulse();
      step();
      check("R6 level request held", irq_pull, 1);
      clear_flag();
      check("R6 level request released", irq_pull, 0);
      check("R6 flag cleared", flag, 0);

      // R7: pulse style, window per source
      pulse_mode = 1'b1;
      src_sel = 2'd1;
      tick(1);
      check("R7 pulse raised src1", irq_pull, 1);
      clear_flag();
      check("R7 clear does not end pulse", irq_pull, 1);
      ref_pulse(); ref_pulse();
      check("R7 src1 still high after 2 ref", irq_pull, 1);
      ref_pulse();
      check("R7 src1 released at 3rd ref", irq_pull, 0);

      src_sel = 2'd2;
      tick(2);
      check("R7 pulse raised src2", irq_pull, 1);
      repeat (4) ref_pulse();
      check("R7 src2 still high after 4 ref", irq_pull, 1);
      ref_pulse();
      check("R7 src2 released at 5th ref", irq_pull, 0);
      check("R7 flag stays after pulse", flag, 1);
      clear_flag();

      src_sel = 2'd3;
      tick(3);
      check("R7 pulse raised src3", irq_pull, 1);
      ref_pulse();
      check("R7 src3 released at 1st ref", irq_pull, 0);
      clear_flag();

      // R8: interrupt enable gating
      pulse_mode = 1'b0;
      irq_en = 1'b0;
      tick(3);
      check("R8 no request while disabled", irq_pull, 0);
      check("R8 flag set while disabled", flag, 1);
      irq_en = 1'b1;
      step();
      check("R8 old event not shown", irq_pull, 0);
      clear_flag();
      tick(3);
      check("R8 request when enabled", irq_pull, 1);
      irq_en = 1'b0;
      step();
      check("R8 request dropped on disable", irq_pull, 0);
      irq_en = 1'b1;
      step();
      check("R8 request not restored", irq_pull, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule